// File: doc/BRIEF.md
# Universal Shift Register

A shift register of parameterized width that holds one word and, on each rising clock edge, either keeps it, reloads one of two fixed constants, captures a parallel word, or moves every bit one place. A level-sensitive preset input forces the register to a preset constant immediately, with no clock needed. The same constant is also the power-on contents.

At elaboration, the direction mode selects one of three behaviours: always right, always left, or chosen each cycle by a direction pin. The style selects how the vacated end is filled:

- **Logical:** the fill comes from a serial input.
- **Arithmetic:** the sign bit is copied on right shifts.
- **Circular:** the bit that leaves one end re-enters at the other.

The full word is brought out, together with its most and least significant bits as serial taps. The block fits serial-in/parallel-out, parallel-in/serial-out and serial-in/serial-out uses.

Top module: `uni_shift_reg`

## Requirements
- R1: While `preset` is high, `q` equals PRESET_VAL without waiting for a clock edge, whatever the other inputs are. Power-on contents are that same constant. PRESET_VAL defaults to zero.
- R2: A rising edge with `clk_en` and `sync_ld` both high loads SYNC_VAL (default zero), even when `load` is also high.
- R3: A rising edge with `clk_en` and `load` high and `sync_ld` low stores `d_in`.
- R4: A rising edge with `clk_en` low leaves `q` unchanged, whatever `sync_ld`, `load`, `dir_right` and the serial inputs are.
- R5: A shift happens on an edge with `clk_en` high and both `sync_ld` and `load` low. The direction depends on OP_MODE:
  - DIR_PIN: `dir_right` = 1 moves bits from MSB toward LSB (right); `dir_right` = 0 moves them from LSB toward MSB (left).
  - DIR_RIGHT: every shift is right and `dir_right` is ignored.
  - DIR_LEFT: every shift is left and `dir_right` is ignored.
- R6: In the logical style, a right shift puts `ms_in` into the MSB and a left shift puts `ls_in` into the LSB. The other serial input has no effect.
- R7: In the arithmetic style, a right shift keeps the MSB (sign) and copies it into the next bit down, with `ms_in` ignored. A left shift puts `ls_in` into the LSB.
- R8: In the circular style, a right shift moves the old LSB into the MSB and a left shift moves the old MSB into the LSB. Both serial inputs are ignored.
- R9: `ms_out` always equals bit WIDTH-1 of `q`, and `ls_out` always equals bit 0 of `q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| preset | input | 1 | Level-sensitive asynchronous preset to PRESET_VAL |
| sync_ld | input | 1 | Synchronous load of SYNC_VAL (qualified by clk_en) |
| load | input | 1 | Parallel load of d_in (qualified by clk_en) |
| clk_en | input | 1 | Enables every clocked action |
| dir_right | input | 1 | 1 = shift right, 0 = shift left; used only when OP_MODE is DIR_PIN |
| ms_in | input | 1 | Serial fill for the MSB on a right shift (logical style only) |
| ls_in | input | 1 | Serial fill for the LSB on a left shift (logical and arithmetic styles) |
| d_in | input | WIDTH | Parallel data word |
| q | output | WIDTH | Register contents |
| ms_out | output | 1 | MSB serial tap |
| ls_out | output | 1 | LSB serial tap |

## Verification
The bench builds five 8-bit copies with PRESET_VAL 8'hA5 and SYNC_VAL 8'h3C, and drives all of them with the same stimulus:
- Logical, arithmetic and circular styles, each with the direction pin enabled. This covers every style in both directions, including sign copying after a word with its MSB set.
- Logical style fixed to the right, and logical style fixed to the left. These show that the direction pin is ignored outside the pin-controlled mode.

The two distinct constants show that a preset and a synchronous load are told apart. The overlapping controls, including a preset raised between clock edges while a load is pending, exercise every step of the priority order.

// File: rtl/usr_pkg.sv
package usr_pkg;

    // Direction mode fixed at elaboration
    typedef enum logic [1:0] {
        DIR_RIGHT = 2'd0,
        DIR_LEFT  = 2'd1,
        DIR_PIN   = 2'd2
    } shift_op_e;

    // Fill style for the vacated end
    typedef enum logic [1:0] {
        STY_LOGICAL = 2'd0,
        STY_ARITH   = 2'd1,
        STY_CIRC    = 2'd2
    } shift_style_e;

    // Action selected for the coming clock edge
    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_SYNC = 3'd1,
        ACT_LOAD = 3'd2,
        ACT_SHR  = 3'd3,
        ACT_SHL  = 3'd4
    } act_e;

    // Synchronous control inputs grouped for the decoder
    typedef struct packed {
        logic en;
        logic sync;
        logic load;
        logic dir_right;
    } ctl_t;

endpackage

// File: rtl/usr_ctrl.sv
module usr_ctrl
    import usr_pkg::*;
#(
    parameter shift_op_e OP_MODE = DIR_PIN
) (
    input  ctl_t ctl,
    output act_e act
);

    // Priority: enable gate, sync constant, parallel load, then shift
    always_comb begin
        if (!ctl.en) begin
            act = ACT_HOLD;
        end else if (ctl.sync) begin
            act = ACT_SYNC;
        end else if (ctl.load) begin
            act = ACT_LOAD;
        end else begin
            case (OP_MODE)
                DIR_RIGHT: act = ACT_SHR;
                DIR_LEFT:  act = ACT_SHL;
                default:   act = ctl.dir_right ? ACT_SHR : ACT_SHL;
            endcase
        end
    end

endmodule

// File: rtl/usr_shifter.sv
module usr_shifter
    import usr_pkg::*;
#(
    parameter int           WIDTH = 8,
    parameter shift_style_e STYLE = STY_LOGICAL
) (
    input  logic [WIDTH-1:0] cur,
    input  logic             ms_in,
    input  logic             ls_in,
    output logic [WIDTH-1:0] shr_val,
    output logic [WIDTH-1:0] shl_val
);

    localparam int MSB = WIDTH - 1;

    logic fill_r;
    logic fill_l;

    generate
        if (STYLE == STY_ARITH) begin : g_arith
            logic unused_ms;
            assign unused_ms = ms_in;
            assign fill_r    = cur[MSB];
            assign fill_l    = ls_in;
        end else if (STYLE == STY_CIRC) begin : g_circ
            logic unused_serial;
            assign unused_serial = ms_in ^ ls_in;
            assign fill_r        = cur[0];
            assign fill_l        = cur[MSB];
        end else begin : g_logical
            assign fill_r = ms_in;
            assign fill_l = ls_in;
        end
    endgenerate

    assign shr_val = {fill_r, cur[MSB:1]};
    assign shl_val = {cur[MSB-1:0], fill_l};

endmodule

// File: rtl/uni_shift_reg.sv
module uni_shift_reg
    import usr_pkg::*;
#(
    parameter int               WIDTH      = 8,
    parameter shift_op_e        OP_MODE    = DIR_PIN,
    parameter shift_style_e     STYLE      = STY_LOGICAL,
    parameter logic [WIDTH-1:0] PRESET_VAL = '0,
    parameter logic [WIDTH-1:0] SYNC_VAL   = '0
) (
    input  logic             clk,
    input  logic             preset,
    input  logic             sync_ld,
    input  logic             load,
    input  logic             clk_en,
    input  logic             dir_right,
    input  logic             ms_in,
    input  logic             ls_in,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q,
    output logic             ms_out,
    output logic             ls_out
);

    localparam int MSB = WIDTH - 1;

    ctl_t             ctl;
    act_e             act;
    logic [WIDTH-1:0] shr_val;
    logic [WIDTH-1:0] shl_val;
    logic [WIDTH-1:0] nxt;
    logic [WIDTH-1:0] q_r;

    assign ctl = '{en: clk_en, sync: sync_ld, load: load, dir_right: dir_right};

    usr_ctrl #(.OP_MODE(OP_MODE)) u_ctrl (
        .ctl (ctl),
        .act (act)
    );

    usr_shifter #(.WIDTH(WIDTH), .STYLE(STYLE)) u_shifter (
        .cur     (q_r),
        .ms_in   (ms_in),
        .ls_in   (ls_in),
        .shr_val (shr_val),
        .shl_val (shl_val)
    );

    always_comb begin
        case (act)
            ACT_SYNC: nxt = SYNC_VAL;
            ACT_LOAD: nxt = d_in;
            ACT_SHR:  nxt = shr_val;
            ACT_SHL:  nxt = shl_val;
            default:  nxt = q_r;
        endcase
    end

    always_ff @(posedge clk or posedge preset) begin
        if (preset) q_r <= PRESET_VAL;
        else        q_r <= nxt;
    end

    assign q      = q_r;
    assign ms_out = q_r[MSB];
    assign ls_out = q_r[0];

    // Port-level checks
    AST_PRESET_VAL: assert property (@(posedge clk) preset |-> q == PRESET_VAL); // R1
    AST_SYNC_WINS: assert property (@(posedge clk) disable iff (preset)
        (clk_en && sync_ld) |=> q == SYNC_VAL); // R2
    AST_PAR_LOAD: assert property (@(posedge clk) disable iff (preset)
        (clk_en && !sync_ld && load) |=> q == $past(d_in)); // R3
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (preset)
        !clk_en |=> $stable(q)); // R4
    AST_MOVE_RIGHT: assert property (@(posedge clk) disable iff (preset)
        act == ACT_SHR |=> q[MSB-1:0] == $past(q[MSB:1])); // R5
    AST_MOVE_LEFT: assert property (@(posedge clk) disable iff (preset)
        act == ACT_SHL |=> q[MSB:1] == $past(q[MSB-1:0])); // R5

    generate
        if (STYLE == STY_LOGICAL) begin : g_chk_logic
            AST_FILL_MSB: assert property (@(posedge clk) disable iff (preset)
                act == ACT_SHR |=> q[MSB] == $past(ms_in)); // R6
        end else if (STYLE == STY_ARITH) begin : g_chk_arith
            AST_SIGN_KEEP: assert property (@(posedge clk) disable iff (preset)
                act == ACT_SHR |=> q[MSB] == $past(q[MSB])); // R7
        end else begin : g_chk_circ
            AST_ONES_KEEP: assert property (@(posedge clk) disable iff (preset)
                (act == ACT_SHR || act == ACT_SHL) |=> $countones(q) == $countones($past(q))); // R8
        end
    endgenerate

endmodule

// File: tb/uni_shift_reg_bench.sv
module uni_shift_reg_bench;
    import usr_pkg::*;

    localparam logic [7:0] PV = 8'hA5;
    localparam logic [7:0] SV = 8'h3C;

    typedef struct packed {
        logic       sync;
        logic       load;
        logic       en;
        logic       dir;
        logic       msi;
        logic       lsi;
        logic [7:0] din;
        logic [7:0] exp;
    } vec_t;

    // Expected column applies to the logical, pin-direction copy
    localparam vec_t VEC [12] = '{
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, 8'hA5},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h96, 8'h96},
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3C},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h9E},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'h00, 8'h4F},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h9F},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 8'h3E},
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h3E},
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h81, 8'h81},
        '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h40},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h80},
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h01}
    };

    logic       clk = 1'b0;
    logic       preset, sync_ld, load, clk_en, dir_right, ms_in, ls_in;
    logic [7:0] d_in;
    logic [7:0] q_m, q_a, q_c, q_r, q_l;
    logic       mso_m, lso_m, mso_a, lso_a, mso_c, lso_c, mso_r, lso_r, mso_l, lso_l;
    logic [7:0] e_a, e_c, e_r, e_l;
    int         checks = 0;
    int         errors = 0;

    always #5 clk = ~clk;

    uni_shift_reg #(.WIDTH(8), .OP_MODE(DIR_PIN), .STYLE(STY_LOGICAL), .PRESET_VAL(PV), .SYNC_VAL(SV))
    u_uni_shift_reg (.clk(clk), .preset(preset), .sync_ld(sync_ld), .load(load), .clk_en(clk_en),
        .dir_right(dir_right), .ms_in(ms_in), .ls_in(ls_in), .d_in(d_in), .q(q_m), .ms_out(mso_m), .ls_out(lso_m));
    uni_shift_reg #(.WIDTH(8), .OP_MODE(DIR_PIN), .STYLE(STY_ARITH), .PRESET_VAL(PV), .SYNC_VAL(SV))
    u_arith (.clk(clk), .preset(preset), .sync_ld(sync_ld), .load(load), .clk_en(clk_en),
        .dir_right(dir_right), .ms_in(ms_in), .ls_in(ls_in), .d_in(d_in), .q(q_a), .ms_out(mso_a), .ls_out(lso_a));
    uni_shift_reg #(.WIDTH(8), .OP_MODE(DIR_PIN), .STYLE(STY_CIRC), .PRESET_VAL(PV), .SYNC_VAL(SV))
    u_circ (.clk(clk), .preset(preset), .sync_ld(sync_ld), .load(load), .clk_en(clk_en),
        .dir_right(dir_right), .ms_in(ms_in), .ls_in(ls_in), .d_in(d_in), .q(q_c), .ms_out(mso_c), .ls_out(lso_c));
    uni_shift_reg #(.WIDTH(8), .OP_MODE(DIR_RIGHT), .STYLE(STY_LOGICAL), .PRESET_VAL(PV), .SYNC_VAL(SV))
    u_fixr (.clk(clk), .preset(preset), .sync_ld(sync_ld), .load(load), .clk_en(clk_en),
        .dir_right(dir_right), .ms_in(ms_in), .ls_in(ls_in), .d_in(d_in), .q(q_r), .ms_out(mso_r), .ls_out(lso_r));
    uni_shift_reg #(.WIDTH(8), .OP_MODE(DIR_LEFT), .STYLE(STY_LOGICAL), .PRESET_VAL(PV), .SYNC_VAL(SV))
    u_fixl (.clk(clk), .preset(preset), .sync_ld(sync_ld), .load(load), .clk_en(clk_en),
        .dir_right(dir_right), .ms_in(ms_in), .ls_in(ls_in), .d_in(d_in), .q(q_l), .ms_out(mso_l), .ls_out(lso_l));

    // Reference next-state from the requirements
    function automatic logic [7:0] model(input logic [7:0] cur, input vec_t s,
                                         input shift_style_e sty, input shift_op_e op);
        logic go_right;
        if (!s.en)  return cur;
        if (s.sync) return SV;
        if (s.load) return s.din;
        go_right = (op == DIR_RIGHT) || (op == DIR_PIN && s.dir);
        if (go_right) begin
            case (sty)
                STY_ARITH: return {cur[7], cur[7:1]};
                STY_CIRC:  return {cur[0], cur[7:1]};
                default:   return {s.msi, cur[7:1]};
            endcase
        end
        if (sty == STY_CIRC) return {cur[6:0], cur[7]};
        return {cur[6:0], s.lsi};
    endfunction

    function automatic string tag_of(input vec_t s, input string shift_tag);
        if (!s.en)  return "R4";
        if (s.sync) return "R2";
        if (s.load) return "R3";
        return shift_tag;
    endfunction

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input logic [7:0] exp, input string req);
        check(req, "logical/pin", q_m, exp);
        check(req, "arith/pin", q_a, exp);
        check(req, "circ/pin", q_c, exp);
        check(req, "logical/right", q_r, exp);
        check(req, "logical/left", q_l, exp);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        preset = 1'b1; sync_ld = 1'b0; load = 1'b0; clk_en = 1'b0;
        dir_right = 1'b0; ms_in = 1'b0; ls_in = 1'b0; d_in = 8'h00;
        @(negedge clk);
        check_all(PV, "R1");
        check("R9", "ms_out", {7'd0, mso_m}, {7'd0, PV[7]});
        check("R9", "ls_out", {7'd0, lso_m}, {7'd0, PV[0]});
        preset = 1'b0;
        e_a = PV; e_c = PV; e_r = PV; e_l = PV;

        foreach (VEC[i]) begin
            sync_ld = VEC[i].sync; load = VEC[i].load; clk_en = VEC[i].en;
            dir_right = VEC[i].dir; ms_in = VEC[i].msi; ls_in = VEC[i].lsi; d_in = VEC[i].din;
            e_a = model(e_a, VEC[i], STY_ARITH, DIR_PIN);
            e_c = model(e_c, VEC[i], STY_CIRC, DIR_PIN);
            e_r = model(e_r, VEC[i], STY_LOGICAL, DIR_RIGHT);
            e_l = model(e_l, VEC[i], STY_LOGICAL, DIR_LEFT);
            @(posedge clk);
            @(negedge clk);
            check(tag_of(VEC[i], "R6"), "logical/pin", q_m, VEC[i].exp);
            check(tag_of(VEC[i], "R7"), "arith/pin", q_a, e_a);
            check(tag_of(VEC[i], "R8"), "circ/pin", q_c, e_c);
            check(tag_of(VEC[i], "R5"), "fixed right", q_r, e_r);
            check(tag_of(VEC[i], "R5"), "fixed left", q_l, e_l);
            check("R9", "ms_out", {7'd0, mso_m}, {7'd0, VEC[i].exp[7]});
            check("R9", "ls_out", {7'd0, lso_m}, {7'd0, VEC[i].exp[0]});
            check("R9", "arith taps", {6'd0, mso_a, lso_a}, {6'd0, e_a[7], e_a[0]});
        end

        // Arithmetic right shift of a negative word keeps copying the sign
        d_in = 8'hC4; load = 1'b1; sync_ld = 1'b0; clk_en = 1'b1;
        @(posedge clk); @(negedge clk);
        load = 1'b0; dir_right = 1'b1; ms_in = 1'b0;
        @(posedge clk); @(negedge clk);
        check("R7", "arith sign copy", q_a, 8'hE2);
        check("R8", "circ rotate right", q_c, 8'h62);

        // Preset raised between edges while a load is pending
        clk_en = 1'b1; load = 1'b1; d_in = 8'h00;
        #2 preset = 1'b1;
        #1 check_all(PV, "R1");
        @(posedge clk); #1;
        check_all(PV, "R1");
        @(negedge clk);
        preset = 1'b0; clk_en = 1'b0;
        @(posedge clk); @(negedge clk);
        check_all(PV, "R4");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule